// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a small on-chip data store reached through a 32-bit byte address. Its 32-bit data path is split into four 8-bit lanes. A 2-bit operation code picks one of four accesses: a full-word load, or a store of one byte, two bytes or four bytes. Every lane has its own write enable, so a partial store changes only the bytes it addresses and leaves the rest of the word alone.

Stores take effect on the rising clock edge. A load returns the addressed word combinationally in the same cycle. Byte order is little-endian: the byte at the lowest address of a word sits on data bits 7:0. Accesses that are not aligned are not trapped. The low address bits a format has no use for are dropped. Address bits at and above log2 of the memory size are dropped as well, so the store repeats through the address space.

The depth is set by a parameter given in bytes. The word index is taken from the address bits just above the two lane-select bits.

Top module: `dmem_ctrl`

## Requirements
- R1: After reset every byte of the store holds zero, so a load from any address returns 0x00000000.
- R2: With the enable high and op code 00, the read data equals the word containing the address, with address bits 1:0 ignored. The byte at the lowest address appears on bits 7:0 and the highest on bits 31:24. This is valid in the same cycle, and the store is not changed.
- R3: With the enable high and op code 01, write-data bits 7:0 are stored at the rising edge into the byte lane selected by address bits 1:0. The other three bytes of that word keep their values.
- R4: With the enable high and op code 10, write-data bits 15:0 are stored into the byte pair selected by address bit 1, with bits 7:0 at the lower address. Address bit 0 is ignored, and the other pair keeps its value.
- R5: With the enable high and op code 11, all 32 write-data bits are stored into the word containing the address, with address bits 1:0 ignored.
- R6: While the enable is low, no op code changes any byte of the store.
- R7: The read data is 0x00000000 whenever the enable is low or the op code is not 00.
- R8: Address bits at and above log2(MEM_BYTES) are ignored, so two addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears the store |
| mem_en | input | 1 | Access enable |
| mem_op | input | 2 | 00 load word, 01 store byte, 10 store halfword, 11 store word |
| mem_addr | input | ADDR_W | Byte address |
| mem_wdata | input | 32 | Store data, low-aligned for byte and halfword stores |
| mem_rdata | output | 32 | Load data, zero unless a load is enabled |

## Verification
The bench builds the block with MEM_BYTES set to 64, which gives a 16-word store. With that size, a sweep of every word fits easily in the run. It also puts address bit 6 just above the index, so aliasing can be shown with short addresses. ADDR_W keeps its default of 32, so high address bits such as bit 8 are driven during the aliasing check. Each lane and each lane pair is written in turn between full-word patterns, so a wrong lane decode or a lane spilling into its neighbour shows up as a wrong byte on read-back.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_LOAD_WORD  = 2'b00,
        OP_STORE_BYTE = 2'b01,
        OP_STORE_HALF = 2'b10,
        OP_STORE_WORD = 2'b11
    } mem_op_e;

    typedef struct packed {
        logic [LANES-1:0]  we;
        logic [WORD_W-1:0] data;
    } lane_req_t;

endpackage

// File: rtl/dmem_lane_steer.sv
module dmem_lane_steer
    import dmem_pkg::*;
(
    input  logic              en_i,
    input  mem_op_e           op_i,
    input  logic [1:0]        lane_sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    output lane_req_t         req_o
);

    localparam logic [LANES-1:0] ONE_LANE = {{(LANES-1){1'b0}}, 1'b1};
    localparam logic [LANES-1:0] LOW_PAIR = {{(LANES-2){1'b0}}, 2'b11};

    lane_req_t req_d;

    // Turn the op code and the low address bits into per-lane enables,
    // and replicate the store data so every enabled lane sees its byte.
    always_comb begin
        req_d = '0;
        if (en_i) begin
            unique case (op_i)
                OP_STORE_BYTE: begin
                    req_d.we   = ONE_LANE << lane_sel_i;
                    req_d.data = {LANES{wdata_i[LANE_W-1:0]}};
                end
                OP_STORE_HALF: begin
                    req_d.we   = lane_sel_i[1] ? (LOW_PAIR << 2) : LOW_PAIR;
                    req_d.data = {(LANES/2){wdata_i[2*LANE_W-1:0]}};
                end
                OP_STORE_WORD: begin
                    req_d.we   = '1;
                    req_d.data = wdata_i;
                end
                default: begin
                    req_d = '0;
                end
            endcase
        end
    end

    assign req_o = req_d;

endmodule

// File: rtl/dmem_byte_bank.sv
module dmem_byte_bank
    import dmem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANE_W-1:0] wbyte_i,
    output logic [LANE_W-1:0] rbyte_o
);

    typedef struct packed {
        logic [DEPTH-1:0][LANE_W-1:0] cells;
    } bank_state_t;

    bank_state_t st_d;
    bank_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cells[idx_i] = wbyte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rbyte_o = st_q.cells[idx_i];

    // R6: a lane left without its enable keeps every cell.
    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> st_q == $past(st_q));

    // R3: an enabled lane holds the offered byte after the edge.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> st_q.cells[$past(idx_i)] == $past(wbyte_i));

endmodule

// File: rtl/dmem_read_gate.sv
module dmem_read_gate
    import dmem_pkg::*;
(
    input  logic              en_i,
    input  mem_op_e           op_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (en_i && (op_i == OP_LOAD_WORD)) begin
            rdata_d = word_i;
        end
    end

    assign rdata_o = rdata_d;

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MEM_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic [1:0]        mem_op,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_wdata,
    output logic [31:0]       mem_rdata
);

    localparam int WORDS = MEM_BYTES / LANES;
    localparam int OFS_W = $clog2(LANES);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int HI_LO = OFS_W + IDX_W;

    mem_op_e           op;
    logic [OFS_W-1:0]  lane_sel;
    logic [IDX_W-1:0]  word_idx;
    lane_req_t         req;
    logic [WORD_W-1:0] bank_word;
    logic              unused_addr_hi;

    assign op       = mem_op_e'(mem_op);
    assign lane_sel = mem_addr[OFS_W-1:0];
    assign word_idx = mem_addr[OFS_W +: IDX_W];

    // R8: bits above the index never reach the store.
    assign unused_addr_hi = ^mem_addr[ADDR_W-1:HI_LO];

    dmem_lane_steer u_steer (
        .en_i       (mem_en),
        .op_i       (op),
        .lane_sel_i (lane_sel),
        .wdata_i    (mem_wdata),
        .req_o      (req)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmem_byte_bank #(
            .DEPTH (WORDS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (req.we[g]),
            .idx_i   (word_idx),
            .wbyte_i (req.data[g*LANE_W +: LANE_W]),
            .rbyte_o (bank_word[g*LANE_W +: LANE_W])
        );
    end

    dmem_read_gate u_rgate (
        .en_i    (mem_en),
        .op_i    (op),
        .word_i  (bank_word),
        .rdata_o (mem_rdata)
    );

    // Lane-enable checks, placed next to the steering instance they guard.
    p_read_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && op == OP_LOAD_WORD) |-> req.we == '0);

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && op == OP_STORE_BYTE) |-> $countones(req.we) == 1);

    p_half_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && op == OP_STORE_HALF) |-> (req.we == 4'b0011 || req.we == 4'b1100));

    p_word_all_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && op == OP_STORE_WORD) |-> req.we == 4'b1111);

    p_idle_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> req.we == '0);

    p_quiet_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> mem_rdata == '0);

endmodule

// File: tb/dmem_ctrl_bench.sv
module dmem_ctrl_bench;

    localparam int MEM_BYTES = 64;
    localparam int AMASK     = MEM_BYTES - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b0;
    logic [1:0]  mem_op = 2'b00;
    logic [31:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [31:0] mem_rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [7:0] ref_mem [MEM_BYTES];

    always #5 clk = ~clk;

    dmem_ctrl #(.ADDR_W(32), .MEM_BYTES(MEM_BYTES)) u_dmem_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en    (mem_en),
        .mem_op    (mem_op),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference update, written from the requirement text.
    task automatic model_store(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] d);
        int a = int'(addr) & AMASK;
        case (op)
            2'b01: ref_mem[a] = d[7:0];
            2'b10: begin
                a = a & ~1;
                ref_mem[a]   = d[7:0];
                ref_mem[a+1] = d[15:8];
            end
            2'b11: begin
                a = a & ~3;
                for (int k = 0; k < 4; k++) ref_mem[a+k] = d[8*k +: 8];
            end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_word(input logic [31:0] addr);
        int a = (int'(addr) & AMASK) & ~3;
        return {ref_mem[a+3], ref_mem[a+2], ref_mem[a+1], ref_mem[a]};
    endfunction

    task automatic store(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] d);
        @(negedge clk);
        mem_en = 1'b1; mem_op = op; mem_addr = addr; mem_wdata = d;
        model_store(op, addr, d);
        @(negedge clk);
        mem_en = 1'b0;
    endtask

    task automatic load_check(input string req, input logic [31:0] addr);
        @(negedge clk);
        mem_en = 1'b1; mem_op = 2'b00; mem_addr = addr;
        #1 check(req, mem_rdata, model_word(addr));
        mem_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'h00;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        load_check("R1", 32'h0);
        load_check("R1", 32'h24);
        load_check("R1", 32'h3C);
    endtask

    task automatic t_word;
        store(2'b11, 32'h08, 32'hA1B2C3D4);
        load_check("R5", 32'h08);
        store(2'b11, 32'h13, 32'h11223344);   // low bits ignored
        load_check("R5", 32'h10);
        load_check("R2", 32'h12);              // read ignores bits 1:0
        @(negedge clk);
        mem_en = 1'b1; mem_op = 2'b00; mem_addr = 32'h08;
        #1 check("R2", mem_rdata[7:0], 32'hD4);  // little-endian lane 0
        mem_en = 1'b0;
    endtask

    task automatic t_byte;
        store(2'b11, 32'h20, 32'h00000000);
        for (int l = 0; l < 4; l++) begin
            store(2'b01, 32'h20 + l, 32'hFFFFFF50 + l);
            load_check("R3", 32'h20);
        end
        store(2'b11, 32'h24, 32'hDEADBEEF);
        store(2'b01, 32'h26, 32'h0000005A);
        load_check("R3", 32'h24);
    endtask

    task automatic t_half;
        store(2'b11, 32'h28, 32'h89ABCDEF);
        store(2'b10, 32'h29, 32'hFFFF1234);   // bit 0 ignored -> low pair
        load_check("R4", 32'h28);
        store(2'b10, 32'h2B, 32'h00005678);   // high pair
        load_check("R4", 32'h28);
    endtask

    task automatic t_disabled;
        store(2'b11, 32'h30, 32'hCAFEF00D);
        for (int op = 1; op < 4; op++) begin
            @(negedge clk);
            mem_en = 1'b0; mem_op = 2'(op); mem_addr = 32'h30; mem_wdata = 32'h5555AAAA;
            @(negedge clk);
            load_check("R6", 32'h30);
        end
    endtask

    task automatic t_rgate;
        @(negedge clk);
        mem_en = 1'b0; mem_op = 2'b00; mem_addr = 32'h30;
        #1 check("R7", mem_rdata, 32'h0);
        @(negedge clk);
        mem_en = 1'b1; mem_op = 2'b01; mem_addr = 32'h30; mem_wdata = 32'h77;
        model_store(2'b01, 32'h30, 32'h77);
        #1 check("R7", mem_rdata, 32'h0);
        @(negedge clk);
        mem_en = 1'b0;
        load_check("R3", 32'h30);
    endtask

    task automatic t_alias;
        store(2'b11, 32'h00000144, 32'h0BADF00D);   // aliases byte 0x04
        load_check("R8", 32'h04);
        store(2'b01, 32'hFFFFFFC5, 32'h000000EE);   // aliases byte 0x05
        load_check("R8", 32'h00000104);
    endtask

    task automatic t_sweep;
        for (int w = 0; w < MEM_BYTES / 4; w++) begin
            store(2'b11, 32'(w * 4), 32'h01010101 * 32'(w + 1) ^ 32'h5A000000);
        end
        for (int w = 0; w < MEM_BYTES / 4; w++) begin
            load_check("R5", 32'(w * 4));
        end
    endtask

    initial begin
        t_reset();
        t_word();
        t_byte();
        t_half();
        t_disabled();
        t_rgate();
        t_alias();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule